// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This core runs programs held in a byte-addressed memory and keeps every arithmetic operand on an internal push-down stack. A load instruction names a memory location and copies that byte onto the stack. A store instruction names a location, writes the top entry there and removes it. Arithmetic instructions carry no operand field. Each one takes the two uppermost entries, combines them and leaves a single result on top. Because of this, instruction length is either one byte (opcode only) or four bytes (opcode followed by a 24-bit address).

The core reaches instruction bytes and data bytes through one synchronous memory port. Read data returns in the cycle after the address is presented. When the core reaches a stop opcode it halts and makes no further memory accesses. It also halts if the stack would overflow or if an instruction needs more entries than the stack holds; in that case it raises an error flag as well. For example, the expression A = (B+C)*D-E takes eight instructions and 23 code bytes and needs five data accesses.

Top module: `stk_core`

## Requirements
- R1: After reset the program counter is 0, `halt_o` and `stack_err_o` are low, and the core presents a read of address 0 in the first cycle.
- R2: Opcode 0x10 (load) is followed by three address bytes, most significant first. The core reads the byte at that address and places it on top of the stack. The next instruction is fetched at the opcode address plus 4.
- R3: Opcode 0x11 (store) is followed by three address bytes, most significant first. The core writes the top entry to that address and removes it from the stack. The next instruction is fetched at the opcode address plus 4.
- R4: Opcode 0x01 replaces the two uppermost entries with their sum modulo 256. The next fetch is at the opcode address plus 1.
- R5: Opcode 0x02 replaces the two uppermost entries with the second entry minus the top entry, modulo 256.
- R6: Opcode 0x03 replaces the two uppermost entries with the low 8 bits of their product.
- R7: Opcode 0xFF, and any other byte not listed in R2 to R6, raises `halt_o` in the cycle after decode and leaves `stack_err_o` low. From then on no read or write is issued.
- R8: The stack holds 8 entries. Any of the following raises both `halt_o` and `stack_err_o` in the cycle after decode, and no access of that instruction follows its opcode fetch: a load with 8 entries present, a store with none, or an arithmetic opcode with fewer than two.
- R9: Each cycle carries at most one memory access. A read and a write are never issued together, and read data is consumed in the cycle after its address.
- R10: Cycle counts are fixed: a load takes 6 cycles, a store 5 and an arithmetic instruction 2. Every instruction starts with an opcode fetch cycle followed by a decode cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 24 | Byte address of the current access |
| mem_re_o | output | 1 | Read strobe; data is due on `mem_rdata_i` next cycle |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data from the previous cycle's read |
| halt_o | output | 1 | Core has stopped |
| stack_err_o | output | 1 | Core stopped because of a stack overflow or underflow |

## Verification
The expression program for (B+C)*D-E mixes all three arithmetic operations at varying depths. It uses asymmetric address bytes, so a reversed byte order or a swapped subtraction shows up as a wrong address or a wrong result. A second program separates the operand order of subtraction and the truncation of addition and multiplication that overflow 8 bits. A program that pushes eight values and folds them with seven additions drives the stack to its full depth. Further programs each hit one error condition (overflow, empty store, a single-operand add) or an undefined opcode, which tells a stack error apart from a plain halt.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;

  typedef enum logic [7:0] {
    OP_ADD  = 8'h01,
    OP_SUB  = 8'h02,
    OP_MUL  = 8'h03,
    OP_LOAD = 8'h10,
    OP_STOR = 8'h11,
    OP_STOP = 8'hFF
  } opc_e;

  typedef enum logic [2:0] {
    S_FETCH, S_DEC, S_AHI, S_AMID, S_ALO, S_DATA, S_HALT, S_ERR
  } state_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int W = 8
) (
  input  logic [7:0]   op_i,
  input  logic [W-1:0] sos_i,
  input  logic [W-1:0] tos_i,
  output logic [W-1:0] res_o
);
  logic [2*W-1:0] prod;
  assign prod = (2*W)'(sos_i) * (2*W)'(tos_i);

  always_comb begin
    unique case (op_i)
      stk_pkg::OP_SUB: res_o = sos_i - tos_i;
      stk_pkg::OP_MUL: res_o = prod[W-1:0];
      default:         res_o = sos_i + tos_i;
    endcase
  end
endmodule

// File: rtl/stk_lifo.sv
module stk_lifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             fold_i,
  input  logic [W-1:0]     din_i,
  output logic [W-1:0]     tos_o,
  output logic [W-1:0]     sos_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             pair_o
);
  logic [W-1:0]     ent_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] top_idx, sec_idx;

  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
  assign sec_idx = IDX_W'(cnt_q - CNT_W'(2));
  assign tos_o   = ent_q[top_idx];
  assign sos_o   = ent_q[sec_idx];
  assign cnt_o   = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign pair_o  = (cnt_q >= CNT_W'(2));

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[i] <= '0;
      end else if (push_i && cnt_q == CNT_W'(i)) begin
        ent_q[i] <= din_i;
      end else if (fold_i && cnt_q == CNT_W'(i + 2)) begin
        ent_q[i] <= din_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (push_i)            cnt_q <= cnt_q + CNT_W'(1);
    else if (pop_i || fold_i)   cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halt_o,
  output logic              stack_err_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  state_e            st_q, st_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [7:0]        opc_q, opc_d;
  logic [15:0]       abuf_q, abuf_d;

  logic              s_push, s_pop, s_fold, s_full, s_empty, s_pair;
  logic [DATA_W-1:0] s_tos, s_sos, alu_res;
  logic [CNT_W-1:0]  stk_cnt;

  stk_lifo #(.DEPTH(DEPTH), .W(DATA_W)) u_lifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (s_push),
    .pop_i   (s_pop),
    .fold_i  (s_fold),
    .din_i   (s_fold ? alu_res : mem_rdata_i),
    .tos_o   (s_tos),
    .sos_o   (s_sos),
    .cnt_o   (stk_cnt),
    .full_o  (s_full),
    .empty_o (s_empty),
    .pair_o  (s_pair)
  );

  stk_alu #(.W(DATA_W)) u_alu (
    .op_i  (mem_rdata_i),
    .sos_i (s_sos),
    .tos_i (s_tos),
    .res_o (alu_res)
  );

  always_comb begin
    st_d        = st_q;
    pc_d        = pc_q;
    opc_d       = opc_q;
    abuf_d      = abuf_q;
    mem_re_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = pc_q;
    mem_wdata_o = s_tos;
    s_push      = 1'b0;
    s_pop       = 1'b0;
    s_fold      = 1'b0;
    unique case (st_q)
      S_FETCH: begin
        mem_re_o = 1'b1;
        st_d     = S_DEC;
      end
      S_DEC: begin
        opc_d = mem_rdata_i;
        unique case (mem_rdata_i)
          OP_LOAD, OP_STOR: begin
            // overflow / underflow is caught before any address byte is fetched
            if ((mem_rdata_i == OP_LOAD && s_full) || (mem_rdata_i == OP_STOR && s_empty)) begin
              st_d = S_ERR;
            end else begin
              mem_re_o   = 1'b1;
              mem_addr_o = pc_q + ADDR_W'(1);
              st_d       = S_AHI;
            end
          end
          OP_ADD, OP_SUB, OP_MUL: begin
            if (!s_pair) begin
              st_d = S_ERR;
            end else begin
              s_fold = 1'b1;
              pc_d   = pc_q + ADDR_W'(1);
              st_d   = S_FETCH;
            end
          end
          default: st_d = S_HALT;
        endcase
      end
      S_AHI: begin
        abuf_d[15:8] = mem_rdata_i;
        mem_re_o     = 1'b1;
        mem_addr_o   = pc_q + ADDR_W'(2);
        st_d         = S_AMID;
      end
      S_AMID: begin
        abuf_d[7:0] = mem_rdata_i;
        mem_re_o    = 1'b1;
        mem_addr_o  = pc_q + ADDR_W'(3);
        st_d        = S_ALO;
      end
      S_ALO: begin
        mem_addr_o = {abuf_q, mem_rdata_i};
        if (opc_q == OP_LOAD) begin
          mem_re_o = 1'b1;
          st_d     = S_DATA;
        end else begin
          mem_we_o = 1'b1;
          s_pop    = 1'b1;
          pc_d     = pc_q + ADDR_W'(4);
          st_d     = S_FETCH;
        end
      end
      S_DATA: begin
        s_push = 1'b1;
        pc_d   = pc_q + ADDR_W'(4);
        st_d   = S_FETCH;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_FETCH;
      pc_q   <= '0;
      opc_q  <= '0;
      abuf_q <= '0;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      opc_q  <= opc_d;
      abuf_q <= abuf_d;
    end
  end

  assign halt_o      = (st_q == S_HALT) || (st_q == S_ERR);
  assign stack_err_o = (st_q == S_ERR);
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mem_re_o,
  input logic             mem_we_o,
  input logic             halt_o,
  input logic [CNT_W-1:0] cnt_i
);
  assert_one_access_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  assert_halt_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o && !mem_re_o && !mem_we_o);

  assert_depth_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH));

  assert_store_nonempty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> cnt_i != '0);

  assert_store_drops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> cnt_i == $past(cnt_i) - CNT_W'(1));
endmodule

bind stk_core stk_core_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mem_re_o (mem_re_o),
  .mem_we_o (mem_we_o),
  .halt_o   (halt_o),
  .cnt_i    (stk_cnt)
);

// File: tb/stk_core_bench.sv
`timescale 1ns/1ps
module stk_core_bench;
  localparam int DEPTH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] mem_addr;
  logic        mem_re, mem_we, halt, serr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  stk_core #(.DEPTH(DEPTH)) u_stk_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_re_o    (mem_re),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .halt_o      (halt),
    .stack_err_o (serr)
  );

  always #2 clk_i = ~clk_i;

  logic [7:0] mem  [int];
  logic [7:0] mmem [int];

  always @(posedge clk_i) begin
    if (mem_re) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
  end

  typedef struct {
    bit    re;
    bit    we;
    int    addr;
    int    wdata;
    bit    halt;
    bit    err;
    string tag;
  } exp_t;

  exp_t tr[$];
  int   n_run = 0;
  int   n_fail = 0;
  int   lp = 0;

  function automatic void add(bit re, bit we, int a, int wd, bit h, bit e, string tag);
    exp_t x;
    x.re = re; x.we = we; x.addr = a; x.wdata = wd; x.halt = h; x.err = e; x.tag = tag;
    tr.push_back(x);
  endfunction

  function automatic int rd(int a);
    return mmem.exists(a) ? int'(mmem[a]) : 0;
  endfunction

  function automatic int bm(int a);
    return mem.exists(a) ? int'(mem[a]) : 0;
  endfunction

  function automatic void tail(bit e, string tag);
    for (int k = 0; k < 4; k++) add(0, 0, 0, 0, 1, e, tag);
  endfunction

  // reference: expected port trace, one entry per cycle
  task automatic build();
    int  pc = 0;
    int  stk[$];
    bit  done = 0;
    int  steps = 0;
    int  op, a, t, s, r;
    tr.delete();
    while (!done && steps < 100) begin
      steps++;
      op = rd(pc);
      add(1, 0, pc, 0, 0, 0, (tr.size() == 0) ? "R1" : "R10");
      case (op)
        'h10: begin
          if (stk.size() == DEPTH) begin
            add(0, 0, 0, 0, 0, 0, "R8"); tail(1, "R8"); done = 1;
          end else begin
            add(1, 0, pc + 1, 0, 0, 0, "R2");
            add(1, 0, pc + 2, 0, 0, 0, "R2");
            add(1, 0, pc + 3, 0, 0, 0, "R2");
            a = (rd(pc + 1) << 16) | (rd(pc + 2) << 8) | rd(pc + 3);
            add(1, 0, a, 0, 0, 0, "R2");
            add(0, 0, 0, 0, 0, 0, "R10");
            stk.push_back(rd(a));
            pc += 4;
          end
        end
        'h11: begin
          if (stk.size() == 0) begin
            add(0, 0, 0, 0, 0, 0, "R8"); tail(1, "R8"); done = 1;
          end else begin
            add(1, 0, pc + 1, 0, 0, 0, "R3");
            add(1, 0, pc + 2, 0, 0, 0, "R3");
            add(1, 0, pc + 3, 0, 0, 0, "R3");
            a = (rd(pc + 1) << 16) | (rd(pc + 2) << 8) | rd(pc + 3);
            t = stk.pop_back();
            add(0, 1, a, t, 0, 0, "R3");
            mmem[a] = 8'(t);
            pc += 4;
          end
        end
        'h01, 'h02, 'h03: begin
          if (stk.size() < 2) begin
            add(0, 0, 0, 0, 0, 0, "R8"); tail(1, "R8"); done = 1;
          end else begin
            add(0, 0, 0, 0, 0, 0, op == 1 ? "R4" : (op == 2 ? "R5" : "R6"));
            t = stk.pop_back();
            s = stk.pop_back();
            r = (op == 1) ? s + t : ((op == 2) ? s - t : s * t);
            stk.push_back(r & 255);
            pc += 1;
          end
        end
        default: begin
          add(0, 0, 0, 0, 0, 0, "R7"); tail(0, "R7"); done = 1;
        end
      endcase
    end
  endtask

  task automatic cmp(exp_t x);
    bit ok;
    n_run++;
    ok = (mem_re === x.re) && (mem_we === x.we) && (halt === x.halt) && (serr === x.err);
    if (x.re || x.we) ok = ok && (int'(mem_addr) == x.addr);
    if (x.we) ok = ok && (int'(mem_wdata) == x.wdata);
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual re=%0b we=%0b addr=%06h wd=%02h halt=%0b err=%0b expected re=%0b we=%0b addr=%06h wd=%02h halt=%0b err=%0b",
               x.tag, mem_re, mem_we, mem_addr, mem_wdata, halt, serr,
               x.re, x.we, x.addr, x.wdata, x.halt, x.err);
    end
  endtask

  task automatic chk_mem(int a, string tag);
    n_run++;
    if (bm(a) != rd(a)) begin
      n_fail++;
      $display("FAIL %s: mem[%06h] actual %02h expected %02h", tag, a, bm(a), rd(a));
    end
  endtask

  task automatic ld(int b);
    mem[lp] = 8'(b);
    lp++;
  endtask

  task automatic ldi(int op, int a);
    ld(op); ld((a >> 16) & 255); ld((a >> 8) & 255); ld(a & 255);
  endtask

  task automatic start();
    mem.delete();
    lp = 0;
  endtask

  task automatic run();
    mmem = mem;
    build();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    foreach (tr[i]) begin
      cmp(tr[i]);
      @(negedge clk_i);
      #1;
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL R10: watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // expression (B+C)*D-E, R2 R3 R4 R5 R6
    start();
    mem[32'h000200] = 8'd3; mem[32'h000201] = 8'd5;
    mem[32'h010203] = 8'd7; mem[32'h00ABCD] = 8'd6;
    ldi('h10, 'h000200); ldi('h10, 'h000201); ld('h01);
    ldi('h10, 'h010203); ld('h03);
    ldi('h10, 'h00ABCD); ld('h02);
    ldi('h11, 'h123456); ld('hFF);
    run();
    chk_mem('h123456, "R5");
    n_run++;
    if (bm('h123456) != 50) begin
      n_fail++;
      $display("FAIL R5: expression result actual %0d expected 50", bm('h123456));
    end
    chk_mem('h563412, "R3");

    // operand order and wrap, R5 R6 R4
    start();
    mem[32'h300] = 8'h20; mem[32'h301] = 8'h30;
    mem[32'h302] = 8'h13; mem[32'h303] = 8'h11;
    mem[32'h304] = 8'hC0;
    ldi('h10, 'h300); ldi('h10, 'h301); ld('h02); ldi('h11, 'h400);
    ldi('h10, 'h302); ldi('h10, 'h303); ld('h03); ldi('h11, 'h401);
    ldi('h10, 'h304); ldi('h10, 'h304); ld('h01); ldi('h11, 'h402);
    ld('hFF);
    run();
    chk_mem('h400, "R5");
    chk_mem('h401, "R6");
    chk_mem('h402, "R4");

    // full depth then fold, R4 R8
    start();
    for (int k = 0; k < 8; k++) mem[32'h500 + k] = 8'(k + 1);
    for (int k = 0; k < 8; k++) ldi('h10, 'h500 + k);
    for (int k = 0; k < 7; k++) ld('h01);
    ldi('h11, 'h600); ld('hFF);
    run();
    chk_mem('h600, "R4");

    // overflow on ninth load, R8
    start();
    for (int k = 0; k < 9; k++) ldi('h10, 'h700 + k);
    run();

    // store from empty stack, R8
    start();
    ldi('h11, 'h800);
    run();
    chk_mem('h800, "R8");

    // add with one operand, R8
    start();
    mem[32'h900] = 8'h44;
    ldi('h10, 'h900); ld('h01); ldi('h11, 'h901);
    run();
    chk_mem('h901, "R8");

    // undefined opcode halts without error, R7
    start();
    mem[32'hA00] = 8'h09;
    ldi('h10, 'hA00); ld('h55); ldi('h11, 'hA01);
    run();
    chk_mem('hA01, "R7");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule